// File: doc/BRIEF.md
# Floating-Point Status Field Move Unit

This block holds a 32-bit floating-point status and control register built from eight 4-bit fields, next to a 32-bit condition register of the same layout. Its main operation moves one status field into one condition field. A command names a source field and a destination field. The selected status nibble is copied unchanged into the chosen condition field.

In the same cycle the block clears only the sticky exception bits of the source field. Control and mode bits, such as the rounding mode in the last field, are left alone. The invalid-operation summary and the enabled-exception summary are then recomputed from the updated register on every move, including moves that clear nothing.

A plain write port loads the whole status register, typically for setup. A write takes priority over a move for the status register. Field k sits at bits [31-4k : 28-4k], so field 0 is the most significant nibble. Inside a field the bits run from MSB to LSB.

Top module: `fsfm_unit`

## Requirements
- R1: After a cycle with `rst_n` low, both `status_q` and `cond_q` read as zero.
- R2: A cycle with `wr_en` high loads `wr_data` into `status_q` at the next edge, whatever `mv_en` does. With `mv_en` low, `cond_q` is unchanged.
- R3: A cycle with `mv_en` high copies status field `mv_src` (bits [31-4*src : 28-4*src]) from before the edge into condition field `mv_dst` (same placement). All other condition fields are unchanged, and `cond_q` is unchanged when `mv_en` is low.
- R4: A move with source 0 and no write clears status bit 31 (exception summary) and bit 28 (overflow).
- R5: A move with source 1 and no write clears bits 27:24 (underflow, zero-divide, inexact, signalling-NaN invalid). Source 2 clears bits 23:20 (the four infinity/zero invalid bits).
- R6: A move with source 3 and no write clears only bit 19 (invalid compare). Source 5 clears only bits 10:8 (software, square-root and integer-convert invalid).
- R7: A move with source 4, 6 or 7 clears no bit. In particular the rounding-mode bits 1:0 survive every move.
- R8: After any move with no write, bit 29 (invalid summary) equals the OR of bits 24:19 and 10:8 of the new register.
- R9: After any move with no write, bit 30 (enabled-exception summary) equals the OR of (invalid summary AND bit 7), (bit 28 AND bit 6), (bit 27 AND bit 5), (bit 26 AND bit 4) and (bit 25 AND bit 3).
- R10: When `wr_en` and `mv_en` are high together, `status_q` takes `wr_data` and no clearing is applied. The condition field still receives the source nibble read before the edge.
- R11: A move with no write leaves unchanged every status bit outside its clear set, except bits 30 and 29.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load status register from `wr_data` |
| wr_data | input | 32 | Value for a direct status write |
| mv_en | input | 1 | Move status field to condition field |
| mv_src | input | 3 | Source status field index |
| mv_dst | input | 3 | Destination condition field index |
| status_q | output | 32 | Current status and control register |
| cond_q | output | 32 | Current condition register |

## Verification
The bound checker follows several properties from one cycle to the next. These cover the nibble copy into the destination field, the untouched condition fields, the clear set of each source index, the preserved rounding bits, and that both summary bits agree with the register after every move. The bench has to show the rest. That includes the exact register values across long mixed runs of writes and moves, and a field being read twice with its mode bits kept. It also includes the case where a move clears nothing, yet it still turns the summaries on from bits that were loaded stale. The result of a write and a move colliding in one cycle, on both registers, also depends on the bench.

// File: rtl/fsfm_pkg.sv
// Package: shared geometry, bit positions and clear-set table for the
// floating-point status field move unit. Assumes eight 4-bit fields, field 0
// in the top nibble.
package fsfm_pkg;
    localparam int FLD_W   = 4;
    localparam int FLD_N   = 8;
    localparam int REG_W   = FLD_W * FLD_N;
    localparam int IDX_W   = $clog2(FLD_N);

    // Vector bit positions of the named status bits.
    localparam int B_XSUM  = 31;
    localparam int B_ESUM  = 30;
    localparam int B_ISUM  = 29;
    localparam int B_OVF   = 28;
    localparam int B_UNF   = 27;
    localparam int B_ZDV   = 26;
    localparam int B_INX   = 25;
    localparam int B_ISIG  = 24;
    localparam int B_ICMP  = 19;
    localparam int B_ISW   = 10;
    localparam int B_ICVI  = 8;
    localparam int B_EN_I  = 7;
    localparam int B_EN_O  = 6;
    localparam int B_EN_U  = 5;
    localparam int B_EN_Z  = 4;
    localparam int B_EN_X  = 3;

    // Sticky bits cleared when a given field is the move source (MSB first).
    function automatic logic [FLD_W-1:0] clr_nibble(input int unsigned idx);
        case (idx)
            0:       return 4'b1001;
            1:       return 4'b1111;
            2:       return 4'b1111;
            3:       return 4'b1000;
            5:       return 4'b0111;
            default: return 4'b0000;
        endcase
    endfunction
endpackage

// File: rtl/fsfm_field_sel.sv
// Field selector: returns the 4-bit field of a register named by an index.
// Assumes field k occupies the k-th nibble counted from the MSB.
module fsfm_field_sel #(
    parameter int NFLD = 8,
    parameter int FW   = 4,
    localparam int RW  = NFLD * FW,
    localparam int IW  = $clog2(NFLD)
) (
    input  logic [RW-1:0] reg_in,
    input  logic [IW-1:0] idx,
    output logic [FW-1:0] fld_out
);
    logic [FW-1:0] nib [NFLD];

    // Split the register into nibbles, field 0 at the top.
    for (genvar k = 0; k < NFLD; k++) begin : g_split
        assign nib[k] = reg_in[RW-1-FW*k -: FW];
    end

    // Pick the requested nibble.
    always_comb fld_out = nib[idx];
endmodule

// File: rtl/fsfm_clear_mask.sv
// Clear-mask generator: expands the per-field sticky-bit table into a
// full-width mask for the selected source field. Assumes the table in
// fsfm_pkg matches the register geometry.
module fsfm_clear_mask
    import fsfm_pkg::*;
#(
    parameter int NFLD = 8,
    parameter int FW   = 4,
    localparam int RW  = NFLD * FW,
    localparam int IW  = $clog2(NFLD)
) (
    input  logic [IW-1:0] src,
    output logic [RW-1:0] mask
);
    // Place each field's table entry, gated by a match on the index.
    for (genvar k = 0; k < NFLD; k++) begin : g_mask
        localparam logic [FW-1:0] ENTRY = clr_nibble(k);
        assign mask[RW-1-FW*k -: FW] = (src == IW'(k)) ? ENTRY : '0;
    end
endmodule

// File: rtl/fsfm_summary.sv
// Summary logic: derives the invalid-operation summary and the
// enabled-exception summary from a status register value. Pure combinational.
module fsfm_summary
    import fsfm_pkg::*;
#(
    parameter int RW = 32
) (
    input  logic [RW-1:0] reg_in,
    output logic          inv_sum,
    output logic          en_sum
);
    // OR every individual invalid-operation bit.
    always_comb inv_sum = (|reg_in[B_ISIG:B_ICMP]) | (|reg_in[B_ISW:B_ICVI]);

    // OR each exception condition masked by its enable bit.
    always_comb en_sum = (inv_sum        & reg_in[B_EN_I])
                       | (reg_in[B_OVF]  & reg_in[B_EN_O])
                       | (reg_in[B_UNF]  & reg_in[B_EN_U])
                       | (reg_in[B_ZDV]  & reg_in[B_EN_Z])
                       | (reg_in[B_INX]  & reg_in[B_EN_X]);
endmodule

// File: rtl/fsfm_cr_insert.sv
// Condition-field inserter: replaces one nibble of the condition register
// and passes the others through untouched.
module fsfm_cr_insert #(
    parameter int NFLD = 8,
    parameter int FW   = 4,
    localparam int RW  = NFLD * FW,
    localparam int IW  = $clog2(NFLD)
) (
    input  logic [RW-1:0] cond_in,
    input  logic [IW-1:0] dst,
    input  logic [FW-1:0] fld,
    output logic [RW-1:0] cond_out
);
    // Per field: take the new nibble when addressed, else keep the old one.
    for (genvar k = 0; k < NFLD; k++) begin : g_ins
        assign cond_out[RW-1-FW*k -: FW] =
            (dst == IW'(k)) ? fld : cond_in[RW-1-FW*k -: FW];
    end
endmodule

// File: rtl/fsfm_unit.sv
// Top: status register plus condition register with a field move operation.
// A move copies a status field into a condition field, clears that field's
// sticky bits and recomputes both summaries; a direct write overrides the
// status update. Synchronous active-low reset clears both registers.
module fsfm_unit
    import fsfm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [REG_W-1:0]       wr_data,
    input  logic                   mv_en,
    input  logic [IDX_W-1:0]       mv_src,
    input  logic [IDX_W-1:0]       mv_dst,
    output logic [REG_W-1:0]       status_q,
    output logic [REG_W-1:0]       cond_q
);
    logic [FLD_W-1:0] src_fld;
    logic [REG_W-1:0] clr_mask;
    logic [REG_W-1:0] cleared;
    logic [REG_W-1:0] moved;
    logic [REG_W-1:0] cond_next;
    logic             inv_sum;
    logic             en_sum;

    fsfm_field_sel #(.NFLD(FLD_N), .FW(FLD_W)) u_sel (
        .reg_in (status_q),
        .idx    (mv_src),
        .fld_out(src_fld)
    );

    fsfm_clear_mask #(.NFLD(FLD_N), .FW(FLD_W)) u_mask (
        .src (mv_src),
        .mask(clr_mask)
    );

    // Drop the sticky bits of the source field.
    always_comb cleared = status_q & ~clr_mask;

    fsfm_summary #(.RW(REG_W)) u_sum (
        .reg_in (cleared),
        .inv_sum(inv_sum),
        .en_sum (en_sum)
    );

    // Insert the recomputed summaries into the cleared value.
    always_comb begin
        moved         = cleared;
        moved[B_ISUM] = inv_sum;
        moved[B_ESUM] = en_sum;
    end

    fsfm_cr_insert #(.NFLD(FLD_N), .FW(FLD_W)) u_ins (
        .cond_in (cond_q),
        .dst     (mv_dst),
        .fld     (src_fld),
        .cond_out(cond_next)
    );

    // Status register: reset, direct write wins, else move result.
    always_ff @(posedge clk) begin
        if (!rst_n)      status_q <= '0;
        else if (wr_en)  status_q <= wr_data;
        else if (mv_en)  status_q <= moved;
    end

    // Condition register: updated only by a move.
    always_ff @(posedge clk) begin
        if (!rst_n)      cond_q <= '0;
        else if (mv_en)  cond_q <= cond_next;
    end
endmodule

// File: rtl/fsfm_unit_chk.sv
// Checker for fsfm_unit: cycle-to-cycle properties on the move and write
// behaviour, attached by bind. Observes ports only.
module fsfm_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        mv_en,
    input logic [2:0]  mv_src,
    input logic [2:0]  mv_dst,
    input logic [31:0] status_q,
    input logic [31:0] cond_q
);
    function automatic logic [3:0] nib(input logic [31:0] v, input logic [2:0] i);
        return v[31 - 4*i -: 4];
    endfunction

    function automatic logic [31:0] fmask(input logic [2:0] i);
        return 32'hF000_0000 >> (4*i);
    endfunction

    logic mv_only;
    always_comb mv_only = mv_en && !wr_en;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (status_q == 32'h0 && cond_q == 32'h0));

    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> status_q == $past(wr_data));

    p_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mv_en |=> nib(cond_q, $past(mv_dst)) == nib($past(status_q), $past(mv_src)));

    p_others_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mv_en |=> ((cond_q ^ $past(cond_q)) & ~fmask($past(mv_dst))) == 32'h0);

    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_en |=> $stable(cond_q));

    p_f0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_only && mv_src == 3'd0) |=> (!status_q[31] && !status_q[28]));

    p_f12_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_only && (mv_src == 3'd1 || mv_src == 3'd2)) |=> nib(status_q, $past(mv_src)) == 4'h0);

    p_f35_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_only && (mv_src == 3'd3 || mv_src == 3'd5)) |=> (!status_q[19] && status_q[10:8] == 3'b000) ||
        ($past(mv_src) == 3'd3 && !status_q[19]) || ($past(mv_src) == 3'd5 && status_q[10:8] == 3'b000));

    p_rn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mv_only |=> status_q[1:0] == $past(status_q[1:0]));

    p_isum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mv_only |=> status_q[29] == ((|status_q[24:19]) | (|status_q[10:8])));

    p_esum_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mv_only |=> status_q[30] == ((status_q[29] & status_q[7]) | (status_q[28] & status_q[6]) |
                                     (status_q[27] & status_q[5]) | (status_q[26] & status_q[4]) |
                                     (status_q[25] & status_q[3])));

    p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mv_only |=> ((status_q ^ $past(status_q)) & 32'h9FF7_F8FF) == 32'h0 ||
        ($past(mv_src) != 3'd4 && $past(mv_src) < 3'd6));
endmodule

bind fsfm_unit fsfm_unit_chk u_fsfm_unit_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .mv_en   (mv_en),
    .mv_src  (mv_src),
    .mv_dst  (mv_dst),
    .status_q(status_q),
    .cond_q  (cond_q)
);

// File: tb/fsfm_unit_bench.sv
// Bench for fsfm_unit: directed corner cases then seeded random traffic,
// each cycle compared with a model built from the requirements.
module fsfm_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        mv_en = 1'b0;
    logic [2:0]  mv_src = '0;
    logic [2:0]  mv_dst = '0;
    logic [31:0] status_q;
    logic [31:0] cond_q;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] m_stat = '0;
    logic [31:0] m_cond = '0;

    always #2.5 clk = ~clk;

    fsfm_unit u_fsfm_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mv_en(mv_en), .mv_src(mv_src), .mv_dst(mv_dst),
        .status_q(status_q), .cond_q(cond_q)
    );

    // Clear set per source field, from R4..R7.
    function automatic logic [31:0] exp_clear(input logic [2:0] s);
        case (s)
            3'd0: return 32'h9000_0000;
            3'd1: return 32'h0F00_0000;
            3'd2: return 32'h00F0_0000;
            3'd3: return 32'h0008_0000;
            3'd5: return 32'h0000_0700;
            default: return 32'h0;
        endcase
    endfunction

    // Status after a move, from R4..R9 and R11.
    function automatic logic [31:0] exp_move(input logic [31:0] s, input logic [2:0] src);
        logic [31:0] r;
        logic vx;
        r = s & ~exp_clear(src);
        vx = (|r[24:19]) | (|r[10:8]);
        r[29] = vx;
        r[30] = (vx & r[7]) | (r[28] & r[6]) | (r[27] & r[5]) | (r[26] & r[4]) | (r[25] & r[3]);
        return r;
    endfunction

    // Condition register after a move, from R3.
    function automatic logic [31:0] exp_cond(input logic [31:0] c, input logic [31:0] s,
                                             input logic [2:0] src, input logic [2:0] dst);
        logic [31:0] r;
        logic [3:0]  f;
        f = s[31 - 4*src -: 4];
        r = c;
        r[31 - 4*dst -: 4] = f;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, model update, then both outputs checked.
    task automatic step(input string tag, input logic w, input logic [31:0] wd,
                        input logic m, input logic [2:0] s, input logic [2:0] d);
        logic [31:0] ns, nc;
        @(negedge clk);
        wr_en = w; wr_data = wd; mv_en = m; mv_src = s; mv_dst = d;
        ns = m_stat; nc = m_cond;
        if (m) begin
            nc = exp_cond(m_cond, m_stat, s, d);
            ns = exp_move(m_stat, s);
        end
        if (w) ns = wd;
        m_stat = ns; m_cond = nc;
        @(posedge clk);
        #1;
        wr_en = 1'b0; mv_en = 1'b0;
        chk({tag, " status"}, status_q, m_stat);
        chk({tag, " cond"}, cond_q, m_cond);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", status_q, 32'h0);
        chk("R1 reset cond", cond_q, 32'h0);

        step("R2 write", 1'b1, 32'hA5A5_5A5A, 1'b0, 3'd0, 3'd0);
        chk("R2 write literal", status_q, 32'hA5A5_5A5A);

        // R7: rounding mode in field 7 read twice stays intact.
        step("R7 load", 1'b1, 32'h0000_0002, 1'b0, 3'd0, 3'd0);
        step("R7 read1", 1'b0, 32'h0, 1'b1, 3'd7, 3'd7);
        step("R7 read2", 1'b0, 32'h0, 1'b1, 3'd7, 3'd7);
        chk("R7 rounding kept", status_q, 32'h0000_0002);
        chk("R7 cond field 7", cond_q, 32'h0000_0002);

        // R4: field 0 with overflow enabled.
        step("R4 load", 1'b1, 32'hF800_0040, 1'b0, 3'd0, 3'd0);
        step("R4 move", 1'b0, 32'h0, 1'b1, 3'd0, 3'd2);
        chk("R4 literal", status_q, 32'h0800_0040);
        chk("R3 literal dst2", cond_q & 32'h00F0_0000, 32'h00F0_0000);

        step("R5 load", 1'b1, 32'h3FFF_FFFF, 1'b0, 3'd0, 3'd0);
        step("R5 field1", 1'b0, 32'h0, 1'b1, 3'd1, 3'd0);
        step("R5 field2", 1'b0, 32'h0, 1'b1, 3'd2, 3'd1);
        step("R6 load", 1'b1, 32'hFFFF_FFFF, 1'b0, 3'd0, 3'd0);
        step("R6 field3", 1'b0, 32'h0, 1'b1, 3'd3, 3'd3);
        step("R6 field5", 1'b0, 32'h0, 1'b1, 3'd5, 3'd5);
        step("R7 field4", 1'b0, 32'h0, 1'b1, 3'd4, 3'd6);
        step("R7 field6", 1'b0, 32'h0, 1'b1, 3'd6, 3'd4);

        // R8/R9: stale summaries turned on by a move that clears nothing.
        step("R8 load", 1'b1, 32'h0008_0080, 1'b0, 3'd0, 3'd0);
        step("R8 move", 1'b0, 32'h0, 1'b1, 3'd4, 3'd0);
        chk("R8 R9 literal", status_q, 32'h6008_0080);

        // R9: summaries dropped after the only exception is cleared.
        step("R9 load", 1'b1, 32'h6800_0020, 1'b0, 3'd0, 3'd0);
        step("R9 move", 1'b0, 32'h0, 1'b1, 3'd1, 3'd7);
        chk("R9 literal", status_q, 32'h0000_0020);

        // R10: write and move collide.
        step("R10 load", 1'b1, 32'h1234_5678, 1'b0, 3'd0, 3'd0);
        step("R10 both", 1'b1, 32'hCAFE_0001, 1'b1, 3'd3, 3'd5);
        chk("R10 status literal", status_q, 32'hCAFE_0001);
        chk("R10 cond nibble", cond_q[11:8], 4'h4);

        // R11 and all others under random traffic.
        for (int i = 0; i < 600; i++) begin
            logic w, m;
            w = ($urandom % 5) == 0;
            m = ($urandom % 5) < 3;
            step("R11 random", w, $urandom, m, 3'($urandom), 3'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule